// File: doc/BRIEF.md
# Prioritized-Mask Interrupt Controller

This block gathers interrupt requests for a small 8-bit processor core. One control register holds a master enable, a gate for the peripheral group, and an enable and a sticky flag for each of three core sources: timer overflow, external pin and port change. Two further enable/flag register pairs serve the peripheral sources. A flag latches whenever its event occurs, whatever its enables hold. The single request line toward the instruction sequencer is a pure combination of the registered bits.

The port-change source compares the upper four port pins with a snapshot taken at the last read of the port address. A small two-state machine tracks whether they differ. While they differ, the flag is re-set on every cycle, so software must read the port before a clear of the flag can take effect. When the core takes an interrupt, an acknowledge strobe drops the master enable. A return strobe raises it again.

Top module: `irqc_top`

## Requirements
- R1: Address 0 is the control register, read and write: bit 7 master enable, bit 6 peripheral gate, bit 5 timer enable, bit 4 external-pin enable, bit 3 port-change enable, bit 2 timer flag, bit 1 external-pin flag, bit 0 port-change flag. A write is visible on a read in the next cycle.
- R2: A one-cycle event pulse sets its flag at the next edge, regardless of any enable. An event wins over a write in the same cycle. A written 0 clears a flag when no event is present.
- R3: `irq` is the OR over the three core sources of flag AND enable, ANDed with the master enable. It is combinational from the registers.
- R4: A peripheral source contributes to `irq` only when its own enable, the peripheral gate (bit 6) and the master enable (bit 7) are all 1.
- R5: Port change uses two states. SETTLED moves to MISMATCH on the CHANGE_SEEN transition, when `port_hi` differs from the snapshot. MISMATCH returns to SETTLED on READ_SYNC (a read of address 5) or on PINS_RETURN (the pins equal the snapshot again). The port-change flag is set at the second edge after the pins change, and again at every edge while in MISMATCH. A read of address 5 returns {port_hi, 4'b0000}, loads the snapshot and forces SETTLED at that edge.
- R6: Peripheral bank 1 has its enables at address 1 and its flags at address 2. The bits are 7 parallel port, 6 converter, 5 receive, 4 transmit, 3 serial port, 2 capture/compare 1, 1 timer-2 match, 0 timer-1 overflow. Source `p1_src[i]` drives flag bit i.
- R7: Flag bits 5 and 4 of bank 1 show the live levels `p1_src[5]` and `p1_src[4]`, and writes to them are ignored. The other bank-1 flags change only through an event or a bus write.
- R8: Peripheral bank 2 has its enables at address 3 and its flags at address 4. Bit 4 (`p2_src[2]`) is EEPROM write done, bit 3 (`p2_src[1]`) is bus collision and bit 0 (`p2_src[0]`) is capture/compare 2. Bits 6, 5, 2 and 1 always read 0 and ignore writes.
- R9: After reset, every readable register and `irq` is 0.
- R10: `int_ack` clears the master enable at the next edge. `int_ret` sets it. `int_ack` wins over `int_ret`, and both win over a bus write.
- R11: Addresses 6 and 7 read 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (3) | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used only for the port snapshot) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| ev_tmr0 | input | 1 | Timer overflow event pulse |
| ev_ext | input | 1 | External pin event pulse |
| p1_src | input | 8 | Bank-1 sources: bits 5,4 levels, others pulses |
| p2_src | input | 3 | Bank-2 event pulses |
| port_hi | input | 4 | Upper four port pins |
| int_ack | input | 1 | Interrupt accepted by core |
| int_ret | input | 1 | Return from interrupt |
| irq | output | 1 | Interrupt request |

## Verification
Read data and `irq` are combinational, so they follow any register change at the next edge. The bench drives stimulus on falling edges and samples on the following falling edge, one edge after a write or event pulse. The port-change flag passes through the state register first and is due two edges after the pins move. The bench checks that it is still 0 after one edge and 1 after two. It also checks that a flag clear right after the port read sticks, which proves that the read forces SETTLED at the same edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DW = 8;
    localparam int A_CTL  = 0;
    localparam int A_P1EN = 1;
    localparam int A_P1FL = 2;
    localparam int A_P2EN = 3;
    localparam int A_P2FL = 4;
    localparam int A_PORT = 5;
    // control register bit positions
    localparam int B_GIE  = 7;
    localparam int B_PEN  = 6;
    localparam int B_T0E  = 5;
    localparam int B_EXE  = 4;
    localparam int B_PCE  = 3;
    localparam int B_T0F  = 2;
    localparam int B_EXF  = 1;
    localparam int B_PCF  = 0;
    localparam logic [DW-1:0] P1_IMPL = 8'hFF;
    localparam logic [DW-1:0] P1_LIVE = 8'h30;
    localparam logic [DW-1:0] P2_IMPL = 8'h19;
    localparam logic [DW-1:0] P2_LIVE = 8'h00;
    typedef enum logic {PW_SETTLED = 1'b0, PW_MISMATCH = 1'b1} pw_state_t;
endpackage

// File: rtl/irqc_portwatch.sv
module irqc_portwatch #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pins,
    input  logic          port_rd,
    output logic [PW-1:0] snap,
    output logic          chg_evt
);
    import irqc_pkg::*;

    pw_state_t state_q, state_d;

    // next state: a read resynchronises the snapshot at this edge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_SETTLED:  if (!port_rd && (pins != snap)) state_d = PW_MISMATCH;  // CHANGE_SEEN
            PW_MISMATCH: if (port_rd || (pins == snap))  state_d = PW_SETTLED;   // READ_SYNC / PINS_RETURN
            default:     state_d = PW_SETTLED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PW_SETTLED;
            snap    <= '0;
        end else begin
            state_q <= state_d;
            if (port_rd) snap <= pins;
        end
    end

    always_comb begin
        unique case (state_q)
            PW_MISMATCH: chg_evt = 1'b1;
            default:     chg_evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/irqc_flagbank.sv
module irqc_flagbank #(
    parameter int           W    = 8,
    parameter logic [W-1:0] IMPL = '1,
    parameter logic [W-1:0] LIVE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_we,
    input  logic         fl_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] src,
    output logic [W-1:0] en_q,
    output logic [W-1:0] fl_q
);
    logic unused_bits;
    assign unused_bits = ^{src & ~IMPL, wdata & ~IMPL};

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (!IMPL[i]) begin : g_absent
            assign en_q[i] = 1'b0;
            assign fl_q[i] = 1'b0;
        end else begin : g_present
            logic en_r;
            always_ff @(posedge clk) begin
                if (!rst_n)     en_r <= 1'b0;
                else if (en_we) en_r <= wdata[i];
            end
            assign en_q[i] = en_r;
            if (LIVE[i]) begin : g_live
                assign fl_q[i] = src[i];
            end else begin : g_sticky
                logic fl_r;
                always_ff @(posedge clk) begin
                    if (!rst_n) fl_r <= 1'b0;
                    else        fl_r <= src[i] | (fl_we ? wdata[i] : fl_r);
                end
                assign fl_q[i] = fl_r;
            end
        end
    end
endmodule

// File: rtl/irqc_reqtree.sv
module irqc_reqtree
    import irqc_pkg::*;
(
    input  logic [DW-1:0] ctl,
    input  logic [DW-1:0] p1_en,
    input  logic [DW-1:0] p1_fl,
    input  logic [DW-1:0] p2_en,
    input  logic [DW-1:0] p2_fl,
    output logic          irq
);
    logic core_hit, peri_hit;
    always_comb begin
        core_hit = |(ctl[B_T0E:B_PCE] & ctl[B_T0F:B_PCF]);
        peri_hit = (|(p1_en & p1_fl)) | (|(p2_en & p2_fl));
        irq      = ctl[B_GIE] & (core_hit | (ctl[B_PEN] & peri_hit));
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ev_tmr0,
    input  logic          ev_ext,
    input  logic [DW-1:0] p1_src,
    input  logic [2:0]    p2_src,
    input  logic [3:0]    port_hi,
    input  logic          int_ack,
    input  logic          int_ret,
    output logic          irq
);
    logic wr_ctl, wr_p1en, wr_p1fl, wr_p2en, wr_p2fl, port_rd;
    logic [DW-1:0] ctl_q, p1_en, p1_fl, p2_en, p2_fl, p2_vec;
    logic [3:0] snap;
    logic chg_evt;

    assign wr_ctl  = bus_wr && (bus_addr == AW'(A_CTL));
    assign wr_p1en = bus_wr && (bus_addr == AW'(A_P1EN));
    assign wr_p1fl = bus_wr && (bus_addr == AW'(A_P1FL));
    assign wr_p2en = bus_wr && (bus_addr == AW'(A_P2EN));
    assign wr_p2fl = bus_wr && (bus_addr == AW'(A_P2FL));
    assign port_rd = bus_rd && (bus_addr == AW'(A_PORT));
    assign p2_vec  = {3'b000, p2_src[2], p2_src[1], 2'b00, p2_src[0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            if (int_ack)     ctl_q[B_GIE] <= 1'b0;
            else if (int_ret) ctl_q[B_GIE] <= 1'b1;
            else if (wr_ctl)  ctl_q[B_GIE] <= bus_wdata[B_GIE];
            if (wr_ctl) ctl_q[B_PEN:B_PCE] <= bus_wdata[B_PEN:B_PCE];
            ctl_q[B_T0F] <= ev_tmr0 | (wr_ctl ? bus_wdata[B_T0F] : ctl_q[B_T0F]);
            ctl_q[B_EXF] <= ev_ext  | (wr_ctl ? bus_wdata[B_EXF] : ctl_q[B_EXF]);
            ctl_q[B_PCF] <= chg_evt | (wr_ctl ? bus_wdata[B_PCF] : ctl_q[B_PCF]);
        end
    end

    irqc_portwatch #(.PW(4)) u_pw (
        .clk(clk), .rst_n(rst_n), .pins(port_hi), .port_rd(port_rd),
        .snap(snap), .chg_evt(chg_evt)
    );

    irqc_flagbank #(.W(DW), .IMPL(P1_IMPL), .LIVE(P1_LIVE)) u_bank1 (
        .clk(clk), .rst_n(rst_n), .en_we(wr_p1en), .fl_we(wr_p1fl),
        .wdata(bus_wdata), .src(p1_src), .en_q(p1_en), .fl_q(p1_fl)
    );

    irqc_flagbank #(.W(DW), .IMPL(P2_IMPL), .LIVE(P2_LIVE)) u_bank2 (
        .clk(clk), .rst_n(rst_n), .en_we(wr_p2en), .fl_we(wr_p2fl),
        .wdata(bus_wdata), .src(p2_vec), .en_q(p2_en), .fl_q(p2_fl)
    );

    irqc_reqtree u_tree (
        .ctl(ctl_q), .p1_en(p1_en), .p1_fl(p1_fl),
        .p2_en(p2_en), .p2_fl(p2_fl), .irq(irq)
    );

    always_comb begin
        if      (bus_addr == AW'(A_CTL))  bus_rdata = ctl_q;
        else if (bus_addr == AW'(A_P1EN)) bus_rdata = p1_en;
        else if (bus_addr == AW'(A_P1FL)) bus_rdata = p1_fl;
        else if (bus_addr == AW'(A_P2EN)) bus_rdata = p2_en;
        else if (bus_addr == AW'(A_P2FL)) bus_rdata = p2_fl;
        else if (bus_addr == AW'(A_PORT)) bus_rdata = {port_hi, 4'b0000};
        else                              bus_rdata = '0;
    end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_rdata,
    input logic          ev_tmr0,
    input logic          int_ack,
    input logic          int_ret,
    input logic          irq,
    input logic [7:0]    ctl_q,
    input logic          chg_evt
);
    p_tmr0_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tmr0 |=> ctl_q[2]);
    p_gated_by_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[7] |-> !irq);
    p_refire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chg_evt |=> ctl_q[0]);
    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(3) || bus_addr == AW'(4)) |-> ((bus_rdata & 8'h66) == 8'h00));
    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> !ctl_q[7]);
    p_ret_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ret && !int_ack) |=> ctl_q[7]);
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= AW'(6)) |-> (bus_rdata == 8'h00));
endmodule

bind irqc_top irqc_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .ev_tmr0(ev_tmr0), .int_ack(int_ack), .int_ret(int_ret), .irq(irq),
    .ctl_q(ctl_q), .chg_evt(chg_evt)
);

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
    logic clk = 0, rst_n = 0;
    logic [2:0] bus_addr = 0;
    logic bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic ev_tmr0 = 0, ev_ext = 0;
    logic [7:0] p1_src = 0;
    logic [2:0] p2_src = 0;
    logic [3:0] port_hi = 0;
    logic int_ack = 0, int_ret = 0, irq;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irqc_top dut (.*);

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // drive a write; returns just after the next falling edge
    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    // combinational peek, no clock
    task automatic peek(logic [2:0] a, output logic [7:0] d);
        bus_addr = a; #0.5 d = bus_rdata;
    endtask

    logic [7:0] v;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state, R11 unmapped
        for (int a = 0; a < 8; a++) begin
            peek(3'(a), v);
            chk($sformatf("R9 reset addr %0d", a), v, (a == 5) ? {port_hi, 4'h0} : 8'h00);
        end
        chk("R9 reset irq", {7'b0, irq}, 8'h00);

        // R1 / R3 exhaustive control sweep
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cv;
            logic ex;
            cv = 8'(c);
            wr(3'd0, cv);
            peek(3'd0, v);
            chk("R1 control readback", v, cv);
            ex = cv[7] & ((cv[5] & cv[2]) | (cv[4] & cv[1]) | (cv[3] & cv[0]));
            chk("R3 core irq", {7'b0, irq}, {7'b0, ex});
        end

        // R2 event latch regardless of enables, event beats write
        wr(3'd0, 8'h00);
        @(negedge clk); ev_tmr0 = 1; @(negedge clk); ev_tmr0 = 0;
        peek(3'd0, v); chk("R2 timer flag", v, 8'h04);
        @(negedge clk); ev_ext = 1; @(negedge clk); ev_ext = 0;
        peek(3'd0, v); chk("R2 ext flag", v, 8'h06);
        chk("R2 no irq when disabled", {7'b0, irq}, 8'h00);
        @(negedge clk); bus_addr = 0; bus_wdata = 8'h00; bus_wr = 1; ev_tmr0 = 1;
        @(negedge clk); bus_wr = 0; ev_tmr0 = 0;
        peek(3'd0, v); chk("R2 event wins over clear", v, 8'h04);
        wr(3'd0, 8'h00);
        peek(3'd0, v); chk("R2 write clears", v, 8'h00);

        // R4 / R6 peripheral bank 1 gating sweep
        for (int i = 0; i < 8; i++) begin
            if (i == 4 || i == 5) continue;
            for (int g = 0; g < 4; g++) begin
                wr(3'd2, 8'h00);
                wr(3'd1, 8'(1 << i));
                wr(3'd0, {g[1], g[0], 6'b0});
                @(negedge clk); p1_src[i] = 1; @(negedge clk); p1_src[i] = 0;
                peek(3'd2, v); chk("R6 bank1 flag", v, 8'(1 << i));
                chk("R4 bank1 gate", {7'b0, irq}, {7'b0, (g == 3)});
            end
        end

        // R7 live bits
        wr(3'd2, 8'hFF);
        peek(3'd2, v); chk("R7 write ignores live bits", v, 8'hCF);
        wr(3'd2, 8'h00);
        @(negedge clk); p1_src[5] = 1; p1_src[4] = 1;
        peek(3'd2, v); chk("R7 live mirror", v, 8'h30);
        wr(3'd2, 8'h00);
        peek(3'd2, v); chk("R7 live not cleared", v, 8'h30);
        wr(3'd1, 8'h20); wr(3'd0, 8'hC0);
        chk("R4 live source irq", {7'b0, irq}, 8'h01);
        @(negedge clk); p1_src[5] = 0; p1_src[4] = 0;
        peek(3'd2, v); chk("R7 live drop", v, 8'h00);
        chk("R4 live drop irq", {7'b0, irq}, 8'h00);
        wr(3'd1, 8'h00);

        // R8 bank 2
        wr(3'd3, 8'hFF);
        peek(3'd3, v); chk("R8 bank2 enables", v, 8'h19);
        wr(3'd4, 8'hFF);
        peek(3'd4, v); chk("R8 bank2 flags", v, 8'h19);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] bitv;
            bitv = (k == 0) ? 8'h01 : (k == 1) ? 8'h08 : 8'h10;
            wr(3'd4, 8'h00);
            wr(3'd3, bitv);
            wr(3'd0, 8'h80);
            @(negedge clk); p2_src[k] = 1; @(negedge clk); p2_src[k] = 0;
            peek(3'd4, v); chk("R8 bank2 event", v, bitv);
            chk("R4 bank2 needs gate", {7'b0, irq}, 8'h00);
            wr(3'd0, 8'hC0);
            chk("R4 bank2 irq", {7'b0, irq}, 8'h01);
        end
        wr(3'd4, 8'h00); wr(3'd3, 8'h00);

        // R10 ack / return
        wr(3'd0, 8'h80);
        @(negedge clk); int_ack = 1; @(negedge clk); int_ack = 0;
        peek(3'd0, v); chk("R10 ack clears", v, 8'h00);
        @(negedge clk); int_ret = 1; @(negedge clk); int_ret = 0;
        peek(3'd0, v); chk("R10 ret sets", v, 8'h80);
        @(negedge clk); int_ret = 1; int_ack = 1; @(negedge clk); int_ret = 0; int_ack = 0;
        peek(3'd0, v); chk("R10 ack wins", v, 8'h00);

        // R11 unmapped writes
        wr(3'd0, 8'h28);
        wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        peek(3'd6, v); chk("R11 addr6 reads 0", v, 8'h00);
        peek(3'd7, v); chk("R11 addr7 reads 0", v, 8'h00);
        peek(3'd0, v); chk("R11 control untouched", v, 8'h28);
        peek(3'd1, v); chk("R11 bank1 untouched", v, 8'h00);

        // R5 port change
        wr(3'd0, 8'h88);
        @(negedge clk); port_hi = 4'hA;
        @(negedge clk); peek(3'd0, v); chk("R5 flag not yet", v, 8'h88);
        @(negedge clk); peek(3'd0, v); chk("R5 flag after two edges", v, 8'h89);
        chk("R5 irq", {7'b0, irq}, 8'h01);
        wr(3'd0, 8'h88);
        peek(3'd0, v); chk("R5 re-set while mismatch", v, 8'h89);
        @(negedge clk); bus_addr = 3'd5; bus_rd = 1; #0.5 v = bus_rdata;
        chk("R5 port read data", v, 8'hA0);
        @(negedge clk); bus_rd = 0;
        wr(3'd0, 8'h88);
        repeat (4) @(negedge clk);
        peek(3'd0, v); chk("R5 clear sticks after read", v, 8'h88);
        chk("R5 irq gone", {7'b0, irq}, 8'h00);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule